// File: doc/BRIEF.md
# Register-Programmed SPI Command Engine

This block is a serial peripheral master that software drives one word at a time through a small register file. Software first programs a clock register and a per-chip-select mode register, then loads up to four 32-bit data registers. A single write to the command register then moves one word of 1 to 128 bits across the serial pins. Software polls the status register between words. The chip select stays asserted from the first word of a frame until software writes an end-of-frame command, so one frame can hold many commands, each with its own length and direction.

The shift path is the data register set itself, viewed as one 128-bit vector (data word 3 on top, data word 0 at the bottom). The bits go out MSB first from position length−1 downwards, and the bits received from the slave enter at bit 0. The transfer is full duplex, so after any word the low bits hold what the slave sent. A read-type command differs from a write only in that it can turn the shared data pin around when 3-pin mode is selected. The register port has no back-pressure: a write is taken in the cycle `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally. Rejected writes are dropped silently, and software sees this only through status and readback.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, status reads 0, every chip-select pin sits at its inactive level (high, since all polarity bits reset to 0), `sclk_o` is low and `sdo_oe` is high.
- R2: The register word addresses are 0 = clock control (bit 31 enable, bits 15:0 divider), 1 = mode (8 bits per chip select), 2 = command (reads 0), 3 = status, and 4..7 = data words 0..3. Clock control, mode and data registers read back what was written.
- R3: The command fields are: chip select in bits 29:28, word length−1 in bits 25:19, kind in bits 18:16, and frame length in bits 11:0. The kind values are 001 read, 010 write, 101 read on the shared pin, 110 write on the shared pin, 111 quad read (carried out as a single-lane read on `sdi_i`) and 100 end of frame. The kinds 000 and 011 leave every output and status bit unchanged.
- R4: A write-type word of L bits drives bits L−1 down to 0 of the vector {data3,data2,data1,data0} on `sdo_o`, MSB first.
- R5: During any word, the received bits shift in at bit 0 of that vector. After L bits, bits L−1..0 hold the received word, with the first bit received at bit L−1.
- R6: Status bit 0 (busy) is set on the clock edge that accepts a read or write command. When the last bit finishes, busy clears and status bit 1 (word complete) sets. The next accepted command clears word complete. The two bits are never both set.
- R7: The selected chip select goes active when a frame's first command is accepted and stays active between words. An end-of-frame command makes it inactive on the next edge and sets word complete. At most one chip select is active at a time.
- R8: The frame length of a frame's first command caps the number of read/write commands in that frame. Further ones are ignored until the frame is ended. A first command with frame length 0 is ignored. The frame-length field of later commands in a frame has no effect.
- R9: While busy, writes to the command, mode and data registers are ignored. Clock control stays writable.
- R10: With enable set, `sclk_o` changes once every divider+1 clock cycles while busy (divider 0 gives one change per cycle). With enable clear, a busy transfer holds `sclk_o` still.
- R11: Mode bits for chip select n: bit 8n is the idle SCLK level (CPOL), bit 8n+1 set makes the chip select active high, and bit 8n+2 (CPHA) set moves sampling to the trailing edge and driving to the leading edge. When clear, sampling is on the leading edge.
- R12: During a shared-pin read, `sdo_oe` is low and the received bits come from `sdo_i`. At all other times `sdo_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | NCS | Chip-select pins, polarity per mode register |
| sdo_o | output | 1 | Serial data out (shared pin in 3-pin mode) |
| sdo_oe | output | 1 | Output enable for the `sdo_o` pin |
| sdo_i | input | 1 | Level seen on the shared data pin |
| sdi_i | input | 1 | Serial data in from the slave |

## Verification
A wrong half-bit phase counter would show up at once as the wrong number of SCLK edges, or as a final SCLK level different from the programmed idle level, at the moment busy falls. A slip of one bit in the shift vector would corrupt the slave's captured word and the readback of data word 0 within that same word. Bad frame bookkeeping would appear on the chip-select pins at the next command or end-of-frame write, either as a line that stays active or as extra SCLK edges on a command that should be refused. A lost busy lock would let a mid-word register write change the bits already on the wire, and the slave model would report this at the end of the word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [2:0] RA_CLK  = 3'd0;
  localparam logic [2:0] RA_MODE = 3'd1;
  localparam logic [2:0] RA_CMD  = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2,
    CK_END   = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic cpol;
    logic cspol;
    logic cpha;
  } lane_cfg_t;

  function automatic cmd_kind_e decode_kind(input logic [2:0] t);
    case (t)
      3'b001, 3'b101, 3'b111: decode_kind = CK_READ;
      3'b010, 3'b110:         decode_kind = CK_WRITE;
      3'b100:                 decode_kind = CK_END;
      default:                decode_kind = CK_NONE;
    endcase
  endfunction

  function automatic lane_cfg_t unpack_cfg(input logic [7:0] b);
    unpack_cfg.cpol  = b[0];
    unpack_cfg.cspol = b[1];
    unpack_cfg.cpha  = b[2];
  endfunction

endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && en && (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (en)        cnt <= (cnt >= div) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/spi_eng_shreg.sv
module spi_eng_shreg #(
  parameter int MAXW = 128,
  parameter int LENW = $clog2(MAXW),
  parameter int NW   = MAXW / 32,
  parameter int IDXW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  input  logic            sh_en,
  input  logic            sh_in,
  input  logic [LENW-1:0] len_m1,
  output logic [MAXW-1:0] vec,
  output logic            msb
);
  logic [MAXW-1:0] shifted;
  assign shifted = {vec[MAXW-2:0], sh_in};
  assign msb     = vec[len_m1];

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [31:0] w;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   w <= '0;
      else if (sh_en)                               w <= shifted[g*32 +: 32];
      else if (wr_en && wr_idx == IDXW'(g))         w <= wr_data;
    end
    assign vec[g*32 +: 32] = w;
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int MAXW  = 128,
  parameter int DIVW  = 16,
  parameter int FLENW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_o,
  output logic           sdo_o,
  output logic           sdo_oe,
  input  logic           sdo_i,
  input  logic           sdi_i
);
  localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int LENW = $clog2(MAXW);
  localparam int NW   = MAXW / 32;
  localparam int IDXW = (NW > 1) ? $clog2(NW) : 1;
  localparam int HCW  = LENW + 1;
  localparam int DCW  = 8 * NCS;

  // programmed state
  logic            clk_en;
  logic [DIVW-1:0] div;
  logic [DCW-1:0]  devctl;

  // transfer state
  logic             busy, wc, frame_act;
  logic [FLENW-1:0] frame_left;
  logic [CSW-1:0]   cs_sel;
  logic [LENW-1:0]  cur_len_m1;
  logic             cur_read, cur_3pin;
  logic             sclk_q, sbit, mosi_q;
  logic [HCW-1:0]   half_cnt;

  // command decode
  logic [CSW-1:0]   c_cs;
  logic [LENW-1:0]  c_len;
  logic [2:0]       c_t;
  logic [FLENW-1:0] c_flen;
  cmd_kind_e        c_kind;
  logic             wr_cmd, frame_ok, start, end_cmd;

  assign c_cs   = reg_wdata[28 +: CSW];
  assign c_len  = reg_wdata[19 +: LENW];
  assign c_t    = reg_wdata[18:16];
  assign c_flen = reg_wdata[FLENW-1:0];
  assign c_kind = decode_kind(c_t);

  assign wr_cmd   = reg_we && (reg_addr == RA_CMD) && !busy;
  assign frame_ok = frame_act ? (frame_left != '0) : (c_flen != '0);
  assign start    = wr_cmd && (c_kind == CK_READ || c_kind == CK_WRITE) && frame_ok;
  assign end_cmd  = wr_cmd && (c_kind == CK_END);

  // per chip-select mode
  lane_cfg_t cfg_cur;
  logic      cpol_new;
  assign cfg_cur  = unpack_cfg(devctl[{cs_sel, 3'b000} +: 8]);
  assign cpol_new = devctl[{c_cs, 3'b000}];

  // rate generator
  logic tick;
  spi_eng_clkdiv #(.DIVW(DIVW)) u_div (
    .clk (clk), .rst_n (rst_n), .run (busy), .en (clk_en), .div (div), .tick (tick)
  );

  logic leading, last_half, rx_in;
  assign leading   = ~half_cnt[0];
  assign last_half = (half_cnt == {cur_len_m1, 1'b1});
  assign rx_in     = cur_3pin ? sdo_i : sdi_i;

  // data registers double as the shift vector
  logic [MAXW-1:0] vec;
  logic            tx_msb, data_wr;
  assign data_wr = reg_we && reg_addr[2] && !busy;

  spi_eng_shreg #(.MAXW(MAXW)) u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr),
    .wr_idx  (reg_addr[IDXW-1:0]),
    .wr_data (reg_wdata),
    .sh_en   (tick && !leading),
    .sh_in   (cfg_cur.cpha ? rx_in : sbit),
    .len_m1  (cur_len_m1),
    .vec     (vec),
    .msb     (tx_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_en     <= 1'b0;
      div        <= '0;
      devctl     <= '0;
      busy       <= 1'b0;
      wc         <= 1'b0;
      frame_act  <= 1'b0;
      frame_left <= '0;
      cs_sel     <= '0;
      cur_len_m1 <= '0;
      cur_read   <= 1'b0;
      cur_3pin   <= 1'b0;
      sclk_q     <= 1'b0;
      sbit       <= 1'b0;
      mosi_q     <= 1'b0;
      half_cnt   <= '0;
    end else begin
      if (reg_we && reg_addr == RA_CLK) begin
        clk_en <= reg_wdata[31];
        div    <= reg_wdata[DIVW-1:0];
      end
      if (reg_we && reg_addr == RA_MODE && !busy)
        devctl <= reg_wdata[DCW-1:0];

      if (start) begin
        busy       <= 1'b1;
        wc         <= 1'b0;
        frame_act  <= 1'b1;
        frame_left <= frame_act ? frame_left - 1'b1 : c_flen - 1'b1;
        if (!frame_act) cs_sel <= c_cs;
        cur_len_m1 <= c_len;
        cur_read   <= (c_kind == CK_READ);
        cur_3pin   <= (c_t == 3'b101) || (c_t == 3'b110);
        sclk_q     <= frame_act ? cfg_cur.cpol : cpol_new;
        half_cnt   <= '0;
        mosi_q     <= 1'b0;
      end else if (end_cmd) begin
        frame_act <= 1'b0;
        wc        <= 1'b1;
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        if (leading) begin
          if (cfg_cur.cpha) mosi_q <= tx_msb;
          else              sbit   <= rx_in;
        end
        if (last_half) begin
          busy <= 1'b0;
          wc   <= 1'b1;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  // pins
  assign sclk_o = busy ? sclk_q : cfg_cur.cpol;
  assign sdo_o  = cfg_cur.cpha ? mosi_q : tx_msb;
  assign sdo_oe = !(busy && cur_3pin && cur_read);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic act;
    assign act     = frame_act && (cs_sel == CSW'(g));
    assign cs_o[g] = act ? devctl[8*g+1] : ~devctl[8*g+1];
  end

  // register readback
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CLK: begin
        reg_rdata[31]       = clk_en;
        reg_rdata[DIVW-1:0] = div;
      end
      RA_MODE: reg_rdata[DCW-1:0] = devctl;
      RA_STAT: reg_rdata[1:0]     = {wc, busy};
      RA_CMD:  reg_rdata          = '0;
      default: reg_rdata          = vec[reg_addr[IDXW-1:0]*32 +: 32];
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NCS  = 4,
  parameter int DIVW = 16,
  parameter int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           wc,
  input logic           sclk_q,
  input logic           clk_en,
  input logic [DIVW-1:0] div,
  input logic [NCS-1:0] cs_o,
  input logic [8*NCS-1:0] devctl,
  input logic [CSW-1:0] cs_sel,
  input logic           sdo_oe,
  input logic           reg_we,
  input logic [2:0]     reg_addr
);
  logic [NCS-1:0] pol, act;
  for (genvar g = 0; g < NCS; g++) begin : g_pol
    assign pol[g] = devctl[8*g+1];
  end
  assign act = ~(cs_o ^ pol);

  logic            sclk_prev;
  logic [DIVW:0]   gap_r, gap_eff;
  assign gap_eff = (sclk_q != sclk_prev) ? '0 : gap_r;
  always_ff @(posedge clk) begin
    sclk_prev <= sclk_q;
    if (!rst_n || !busy || !clk_en || (reg_we && reg_addr == 3'd0)) gap_r <= '0;
    else gap_r <= gap_eff + 1'b1;
  end

  // R6
  busy_wc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && wc));
  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));
  // R9
  cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cs_o));
  // R10
  sclk_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clk_en) |-> (gap_eff <= {1'b0, div}));
  // R10
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en) |=> $stable(sclk_q));
  // R11
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk_q == devctl[{cs_sel, 3'b000}]));
  // R12
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo_oe);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NCS(NCS), .DIVW(DIVW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .wc       (wc),
  .sclk_q   (sclk_q),
  .clk_en   (clk_en),
  .div      (div),
  .cs_o     (cs_o),
  .devctl   (devctl),
  .cs_sel   (cs_sel),
  .sdo_oe   (sdo_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk_o, sdo_o, sdo_oe, sdo_i;
  logic        sdi_i = 1'b0;
  logic        sio_drv = 1'b0;
  logic [3:0]  cs_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdo_i = sdo_oe ? sdo_o : sio_drv;

  spi_cmd_engine u_dut (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .sclk_o (sclk_o),
    .cs_o (cs_o), .sdo_o (sdo_o), .sdo_oe (sdo_oe), .sdo_i (sdo_i), .sdi_i (sdi_i)
  );

  // slave model
  logic         s_on = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_cspol = 1'b0;
  logic         s_3pin = 1'b0, s_lead = 1'b0;
  int           s_cs = 0, s_len = 8;
  logic [127:0] s_tx = '0, s_cap = '0;
  int           sclk_tog = 0;

  task automatic s_drive();
    logic b;
    b = s_tx[s_len-1];
    s_tx = s_tx << 1;
    sio_drv = b;
    sdi_i = s_3pin ? ~b : b;
  endtask

  always @(sclk_o) begin
    sclk_tog++;
    if (s_on && (cs_o[s_cs] == s_cspol)) begin
      if (sclk_o != s_cpol) begin
        s_lead = 1'b1;
        if (!s_cpha) s_cap = {s_cap[126:0], sdo_o};
        else         s_drive();
      end else if (s_lead) begin
        if (s_cpha) s_cap = {s_cap[126:0], sdo_o};
        else        s_drive();
      end
    end
  end

  task automatic slave_setup(input int cs, input logic cpol, input logic cpha,
                             input logic cspol, input logic three, input int len,
                             input logic [127:0] tx);
    s_cs = cs; s_cpol = cpol; s_cpha = cpha; s_cspol = cspol; s_3pin = three;
    s_len = len; s_tx = tx; s_cap = '0; s_lead = 1'b0; s_on = 1'b1;
    if (!cpha) s_drive();
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(input int cs, input int len,
                                         input logic [2:0] kind, input int flen);
    mk_cmd = (32'(cs) << 28) | (32'(len - 1) << 19) | (32'(kind) << 16) | 32'(flen & 12'hfff);
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] st;
    st = '0;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd3, st);
      if (st == 32'd2) break;
    end
    chk(req, st, 32'd2);
  endtask

  task automatic end_frame();
    wr(3'd2, mk_cmd(0, 1, 3'b100, 0));
    s_on = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    rd(3'd3, v);
    chk("R1 status", v, 0);
    chk("R1 cs idle", cs_o, 4'hF);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 oe", sdo_oe, 1);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd0, 32'h8000_0001);
    rd(3'd0, v); chk("R2 clkctl readback", v, 32'h8000_0001);
    wr(3'd1, 32'h0007_0502);
    rd(3'd1, v); chk("R2 mode readback", v, 32'h0007_0502);
    wr(3'd6, 32'hCAFE_1234);
    rd(3'd6, v); chk("R2 data2 readback", v, 32'hCAFE_1234);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_write8();
    logic [31:0] v;
    wr(3'd4, 32'h0000_00A5); wr(3'd5, 32'hFFFF_FFFF);
    slave_setup(0, 0, 0, 0, 0, 8, 128'h5A);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 16));
    rd(3'd3, v); chk("R6 busy after accept", v, 32'd1);
    wait_done("R6 done");
    chk("R4 8-bit write", s_cap[7:0], 8'hA5);
    rd(3'd4, v); chk("R5 full-duplex rx", v[7:0], 8'h5A);
    chk("R7 cs held between words", cs_o, 4'hE);
    end_frame();
    chk("R7 end of frame", cs_o, 4'hF);
    rd(3'd3, v); chk("R7 wc after end", v, 32'd2);
  endtask

  task automatic t_write128();
    logic [127:0] w;
    w = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    wr(3'd4, w[31:0]); wr(3'd5, w[63:32]); wr(3'd6, w[95:64]); wr(3'd7, w[127:96]);
    slave_setup(0, 0, 0, 0, 0, 128, '0);
    wr(3'd2, mk_cmd(0, 128, 3'b010, 1));
    wait_done("R4 128 done");
    chk("R4 128-bit order", s_cap, w);
    end_frame();
  endtask

  task automatic t_read_mode3();
    logic [31:0] v;
    wr(3'd1, 32'h0005_0000);
    slave_setup(2, 1, 1, 0, 0, 16, 128'hBEEF);
    wr(3'd2, mk_cmd(2, 16, 3'b001, 4));
    chk("R7 cs2 active", cs_o, 4'hB);
    wait_done("R11 mode3 done");
    rd(3'd4, v); chk("R5 mode3 read", v[15:0], 16'hBEEF);
    chk("R11 sclk idles high", sclk_o, 1);
    end_frame();
    wr(3'd1, 32'h0);
  endtask

  task automatic t_cspol();
    wr(3'd1, 32'h0000_0200);
    chk("R11 cs1 inactive low", cs_o[1], 0);
    wr(3'd4, 32'h0000_0096);
    slave_setup(1, 0, 0, 1, 0, 8, '0);
    wr(3'd2, mk_cmd(1, 8, 3'b010, 1));
    chk("R11 cs1 active high", cs_o[1], 1);
    wait_done("R11 cspol done");
    chk("R11 cspol write", s_cap[7:0], 8'h96);
    end_frame();
    chk("R11 cs1 released", cs_o[1], 0);
    wr(3'd1, 32'h0);
  endtask

  task automatic t_3pin();
    logic [31:0] v;
    slave_setup(0, 0, 0, 0, 1, 12, 128'hABC);
    wr(3'd2, mk_cmd(0, 12, 3'b101, 1));
    chk("R12 oe low in 3-pin read", sdo_oe, 0);
    wait_done("R12 done");
    rd(3'd4, v); chk("R12 3-pin read data", v[11:0], 12'hABC);
    chk("R12 oe back high", sdo_oe, 1);
    end_frame();
  endtask

  task automatic t_quad();
    logic [31:0] v;
    slave_setup(0, 0, 0, 0, 0, 8, 128'hC3);
    wr(3'd2, mk_cmd(0, 8, 3'b111, 1));
    chk("R3 quad keeps oe", sdo_oe, 1);
    wait_done("R3 quad done");
    rd(3'd4, v); chk("R3 quad read as single lane", v[7:0], 8'hC3);
    end_frame();
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(3'd0, 32'h8000_0003);
    wr(3'd4, 32'h0000_003C);
    slave_setup(0, 0, 0, 0, 0, 8, '0);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 4));
    wr(3'd4, 32'h0000_00FF);
    wr(3'd2, mk_cmd(1, 8, 3'b010, 4));
    wr(3'd1, 32'h0000_0007);
    wait_done("R9 done");
    chk("R9 data write ignored", s_cap[7:0], 8'h3C);
    chk("R9 cmd ignored", cs_o, 4'hE);
    rd(3'd1, v); chk("R9 mode write ignored", v, 0);
    end_frame();
  endtask

  task automatic t_divider();
    realtime t1, t2;
    wr(3'd0, 32'h8000_0003);
    slave_setup(0, 0, 0, 0, 0, 8, '0);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 1));
    @(sclk_o); t1 = $realtime;
    @(sclk_o); t2 = $realtime;
    chk("R10 div=3 spacing", 128'(int'(t2 - t1)), 128'(4*CLK_PERIOD));
    wait_done("R10 div3 done");
    end_frame();
    wr(3'd0, 32'h8000_0000);
    slave_setup(0, 0, 0, 0, 0, 8, '0);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 1));
    @(sclk_o); t1 = $realtime;
    @(sclk_o); t2 = $realtime;
    chk("R10 div=0 spacing", 128'(int'(t2 - t1)), 128'(CLK_PERIOD));
    wait_done("R10 div0 done");
    end_frame();
  endtask

  task automatic t_clk_off();
    logic [31:0] v;
    int t0;
    wr(3'd0, 32'h0000_0000);
    wr(3'd4, 32'h0000_0081);
    slave_setup(0, 0, 0, 0, 0, 8, '0);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 1));
    t0 = sclk_tog;
    repeat (40) @(posedge clk);
    rd(3'd3, v); chk("R10 stalled busy", v, 32'd1);
    chk("R10 no sclk edges", 128'(sclk_tog - t0), 0);
    wr(3'd0, 32'h8000_0001);
    wait_done("R10 resumed");
    chk("R10 resumed data", s_cap[7:0], 8'h81);
    end_frame();
  endtask

  task automatic t_frame_guard();
    logic [31:0] v;
    int t0;
    slave_setup(0, 0, 0, 0, 0, 8, '0);
    wr(3'd2, mk_cmd(0, 8, 3'b010, 2));
    wait_done("R8 word1");
    wr(3'd2, mk_cmd(0, 8, 3'b010, 12'hfff));
    wait_done("R8 word2");
    t0 = sclk_tog;
    wr(3'd2, mk_cmd(0, 8, 3'b010, 12'hfff));
    repeat (10) @(posedge clk);
    rd(3'd3, v); chk("R8 over-length word ignored", v, 32'd2);
    chk("R8 no edges", 128'(sclk_tog - t0), 0);
    end_frame();
    wr(3'd2, mk_cmd(0, 8, 3'b010, 0));
    rd(3'd3, v); chk("R8 zero frame length ignored", v, 32'd2);
    chk("R8 cs stays idle", cs_o, 4'hF);
  endtask

  task automatic t_bad_kind();
    logic [31:0] v;
    int t0;
    t0 = sclk_tog;
    wr(3'd2, mk_cmd(0, 8, 3'b011, 1));
    wr(3'd2, mk_cmd(0, 8, 3'b000, 1));
    repeat (5) @(posedge clk);
    rd(3'd3, v); chk("R3 unused kind ignored", v, 32'd2);
    chk("R3 unused kind cs", cs_o, 4'hF);
    chk("R3 unused kind sclk", 128'(sclk_tog - t0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_write8();
    t_write128();
    t_read_mode3();
    t_cspol();
    t_3pin();
    t_quad();
    t_busy_ignore();
    t_divider();
    t_clk_off();
    t_frame_guard();
    t_bad_kind();
    summary();
  end
endmodule